// File: doc/BRIEF.md
# Query-Based Victim Selector for an Inclusive Cache Set

This block picks the line to replace in one set of an inclusive last-level cache. When a miss arrives and the set has no empty way, the block does not throw out the least-recently-used line at once. It first asks the core, through a back-invalidate query, whether that line may be dropped. The core refuses when the line still lives in one of its private caches. A refused line is moved to the most-recently-used position, and the line that is now least recent is asked about next. This stops the cache from evicting lines that the core uses often but that look cold from the last level.

The search stops when the core agrees, or when the attempt budget runs out. When the budget runs out, the line asked about last is evicted anyway. A reply that does not arrive within a fixed window counts as a refusal and uses one attempt. After the eviction, the new tag is written into the freed way and that way becomes most recent. The set handles one miss at a time. Tag storage and recency are kept per way. Data arrays and memory traffic are handled outside this block.

Top module: `victim_query_sel`

## Requirements
- R1: After reset, miss_ready is 1, qry_valid, evict_valid and fill_done are 0, and every way is empty.
- R2: A miss accepted while any way is empty issues no query and no eviction. fill_done pulses for one cycle in the cycle after acceptance, and fill_way gives the lowest-index empty way.
- R3: Recency is a permutation of the ways, and a filled way becomes most recent. A miss accepted with all ways valid pulses qry_valid for one cycle in the next cycle. qry_tag carries the tag of the least-recent way.
- R4: An accept reply (rsp_valid=1, rsp_accept=1) while waiting evicts the queried line. evict_tries reports the number of queries issued for this miss.
- R5: A reject reply (rsp_valid=1, rsp_accept=0) with attempts below MAX_TRIES (default 2) moves the candidate to most recent. The next query follows one cycle later, for the new least-recent line, so no tag is queried twice within one miss.
- R6: A reject at the attempt limit evicts the current candidate regardless, with evict_tries equal to MAX_TRIES.
- R7: If no reply arrives within TMO cycles (default 8) of waiting, the block treats this as a reject. The next query appears TMO+1 cycles after the previous one.
- R8: Only one miss is in flight. miss_ready is 0 from acceptance until fill_done, and miss_valid is ignored while busy.
- R9: evict_valid is high for exactly one cycle, in the cycle after the deciding reply, with evict_tag set. fill_done follows in the next cycle, with fill_way set to the evicted way. miss_ready returns in the cycle after that.
- R10: A reply that arrives while no query is awaiting an answer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_tag | input | TAG_W | Tag of the missing line |
| miss_ready | output | 1 | Block idle; miss accepted when high with miss_valid |
| qry_valid | output | 1 | One-cycle back-invalidate query |
| qry_tag | output | TAG_W | Tag of the line being queried |
| rsp_valid | input | 1 | Core reply present |
| rsp_accept | input | 1 | 1 = line may be dropped, 0 = line still resident |
| evict_valid | output | 1 | One-cycle eviction notice |
| evict_tag | output | TAG_W | Tag of the evicted line |
| evict_tries | output | $clog2(MAX_TRIES+1) | Queries used for this miss |
| fill_done | output | 1 | One-cycle fill completion |
| fill_way | output | $clog2(WAYS) | Way written by the fill |

## Verification
The bench follows a recency model through a fixed sequence of fills and misses. A design that promoted the wrong way, or forgot to promote, would query a tag already refused, or the wrong line, and the qry_tag check catches that. A reject at the limit must evict the line just refused, not the next least-recent one. The timeout case checks the gap between queries, which exposes an off-by-one in the wait counter. Stray replies in idle and misses presented while busy are driven, to catch a design that latches either one.

// File: rtl/victim_query_sel.sv
module victim_query_sel #(
  parameter int WAYS      = 4,
  parameter int TAG_W     = 16,
  parameter int MAX_TRIES = 2,
  parameter int TMO       = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           miss_valid,
  input  logic [TAG_W-1:0]               miss_tag,
  output logic                           miss_ready,
  output logic                           qry_valid,
  output logic [TAG_W-1:0]               qry_tag,
  input  logic                           rsp_valid,
  input  logic                           rsp_accept,
  output logic                           evict_valid,
  output logic [TAG_W-1:0]               evict_tag,
  output logic [$clog2(MAX_TRIES+1)-1:0] evict_tries,
  output logic                           fill_done,
  output logic [$clog2(WAYS)-1:0]        fill_way
);
  localparam int IW    = $clog2(WAYS);
  localparam int TRY_W = $clog2(MAX_TRIES+1);
  localparam int TMR_W = $clog2(TMO+1);

  typedef enum logic [2:0] {S_IDLE, S_QUERY, S_WAIT, S_EVICT, S_FILL} st_t;
  st_t state;

  logic [TAG_W-1:0] tags [WAYS];
  logic [IW-1:0]    age  [WAYS];
  logic [WAYS-1:0]  vld;
  logic [TAG_W-1:0] new_tag;
  logic [IW-1:0]    cand, lru_way, free_way, prom_way;
  logic [TRY_W-1:0] tries;
  logic [TMR_W-1:0] tmr;
  logic             free_any, reply, refuse, at_limit, promote;

  always_comb begin
    lru_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (age[w] == IW'(WAYS-1)) lru_way = IW'(w);
  end

  always_comb begin
    free_way = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (!vld[w]) free_way = IW'(w);
  end

  assign free_any  = ~&vld;
  assign reply     = state == S_WAIT && (rsp_valid || tmr == TMR_W'(TMO-1));
  assign refuse    = reply && !(rsp_valid && rsp_accept);
  assign at_limit  = tries == TRY_W'(MAX_TRIES);
  assign promote   = (refuse && !at_limit) || state == S_FILL;
  assign prom_way  = (state == S_FILL) ? fill_way : cand;

  assign miss_ready  = state == S_IDLE;
  assign qry_valid   = state == S_QUERY;
  assign qry_tag     = tags[lru_way];
  assign evict_valid = state == S_EVICT;
  assign evict_tag   = tags[cand];
  assign evict_tries = tries;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      vld       <= '0;
      cand      <= '0;
      tries     <= '0;
      tmr       <= '0;
      new_tag   <= '0;
      fill_way  <= '0;
      fill_done <= 1'b0;
      for (int w = 0; w < WAYS; w++) begin
        age[w]  <= IW'(w);
        tags[w] <= '0;
      end
    end else begin
      fill_done <= 1'b0;
      case (state)
        S_IDLE: if (miss_valid) begin
          new_tag <= miss_tag;
          tries   <= '0;
          if (free_any) begin
            fill_way  <= free_way;
            fill_done <= 1'b1;
            state     <= S_FILL;
          end else begin
            state <= S_QUERY;
          end
        end
        S_QUERY: begin
          cand  <= lru_way;
          tries <= tries + 1'b1;
          tmr   <= '0;
          state <= S_WAIT;
        end
        S_WAIT: begin
          tmr <= tmr + 1'b1;
          if (reply) state <= (refuse && !at_limit) ? S_QUERY : S_EVICT;
        end
        S_EVICT: begin
          fill_way  <= cand;
          fill_done <= 1'b1;
          state     <= S_FILL;
        end
        default: begin
          tags[fill_way] <= new_tag;
          vld[fill_way]  <= 1'b1;
          state          <= S_IDLE;
        end
      endcase
      if (promote)
        for (int w = 0; w < WAYS; w++)
          if (IW'(w) == prom_way)          age[w] <= '0;
          else if (age[w] < age[prom_way]) age[w] <= age[w] + 1'b1;
    end
  end
endmodule

// File: rtl/vqs_checker.sv
module vqs_checker #(
  parameter int MAX_TRIES = 2
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           miss_ready,
  input logic                           qry_valid,
  input logic                           evict_valid,
  input logic [$clog2(MAX_TRIES+1)-1:0] evict_tries,
  input logic                           fill_done
);
  p_qry_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    qry_valid |=> !qry_valid);
  p_tries_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> (evict_tries >= 1 && int'(evict_tries) <= MAX_TRIES));
  p_busy_no_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_valid || evict_valid || fill_done) |-> !miss_ready);
  p_evict_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |=> (!evict_valid && fill_done));
  p_ready_after_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> miss_ready);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> (!qry_valid && !evict_valid));
endmodule

bind victim_query_sel vqs_checker #(.MAX_TRIES(MAX_TRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_ready(miss_ready), .qry_valid(qry_valid),
  .evict_valid(evict_valid), .evict_tries(evict_tries), .fill_done(fill_done)
);

// File: tb/sim_victim_query_sel.sv
module sim_victim_query_sel;
  localparam int TMO = 8;
  logic clk = 0, rst_n = 0;
  logic miss_valid = 0, rsp_valid = 0, rsp_accept = 0;
  logic [15:0] miss_tag = '0, qry_tag, evict_tag;
  logic miss_ready, qry_valid, evict_valid, fill_done;
  logic [1:0] evict_tries, fill_way;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  victim_query_sel u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_miss(input logic [15:0] t);
    @(negedge clk); miss_valid = 1; miss_tag = t;
    @(negedge clk); miss_valid = 0;
  endtask

  // act: 0 accept, 1 reject, 2 no reply
  task automatic answer(input string req, input logic [15:0] exp_tag, input int act);
    chk(req, qry_valid, 1);
    chk(req, qry_tag, exp_tag);
    if (act == 2) begin
      for (int i = 0; i < TMO; i++) @(negedge clk);
    end else begin
      @(negedge clk);
      chk("R8", miss_ready, 0);
      rsp_valid = 1; rsp_accept = (act == 0);
      @(negedge clk); rsp_valid = 0; rsp_accept = 0;
    end
  endtask

  task automatic see_evict(input string req, input logic [15:0] t, input int tr, input int way);
    chk(req, evict_valid, 1);
    chk(req, evict_tag, t);
    chk(req, evict_tries, tr);
    @(negedge clk);
    chk("R9", evict_valid, 0);
    chk("R9", fill_done, 1);
    chk("R9", fill_way, way);
    @(negedge clk);
    chk("R9", miss_ready, 1);
  endtask

  task automatic t_reset;
    chk("R1", miss_ready, 1);
    chk("R1", qry_valid, 0);
    chk("R1", evict_valid, 0);
    chk("R1", fill_done, 0);
  endtask

  task automatic t_free_fill;
    for (int w = 0; w < 4; w++) begin
      do_miss(16'hA0 + 16'(w));
      chk("R2", fill_done, 1);
      chk("R2", fill_way, w);
      chk("R2", qry_valid, 0);
      chk("R2", evict_valid, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_accept;
    do_miss(16'hB0);
    answer("R3", 16'hA0, 0);
    see_evict("R4", 16'hA0, 1, 0);
  endtask

  task automatic t_reject_then_accept;
    do_miss(16'hB1);
    answer("R5", 16'hA1, 1);
    answer("R5", 16'hA2, 0);
    see_evict("R5", 16'hA2, 2, 2);
  endtask

  task automatic t_limit;
    do_miss(16'hB2);
    answer("R6", 16'hA3, 1);
    answer("R6", 16'hB0, 1);
    see_evict("R6", 16'hB0, 2, 0);
  endtask

  task automatic t_timeout;
    do_miss(16'hB3);
    answer("R7", 16'hA1, 2);
    chk("R7", qry_valid, 0);
    @(negedge clk);
    answer("R7", 16'hB1, 0);
    see_evict("R7", 16'hB1, 2, 2);
  endtask

  task automatic t_stray_and_busy;
    @(negedge clk); rsp_valid = 1; rsp_accept = 1;
    @(negedge clk); rsp_valid = 0; rsp_accept = 0;
    chk("R10", qry_valid, 0);
    chk("R10", evict_valid, 0);
    do_miss(16'hB4);
    miss_valid = 1; miss_tag = 16'hEE;
    answer("R10", 16'hA3, 1);
    chk("R8", qry_valid, 1);
    answer("R8", 16'hB2, 0);
    miss_valid = 0;
    see_evict("R8", 16'hB2, 2, 0);
    @(negedge clk);
    chk("R8", qry_valid, 0);
    chk("R8", fill_done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_free_fill;
    t_accept;
    t_reject_then_accept;
    t_limit;
    t_timeout;
    t_stray_and_busy;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule